// File: doc/BRIEF.md
# Detector scan timing generator

This block sits on the host side of a charge-integrating detector readout front end. For each scan it produces the control strobes the front end needs: integrator reset, reset-level sample, integrate enable, signal-level sample and read start. It also produces a gated readout clock that stops after a fixed number of pulses. Every phase length comes from a register, counted in system clock cycles. A value below the front end's minimum timing is raised to that minimum. The readout clock half period is also held inside the allowed frequency band for the selected output mode.

There are two scan modes. In overlapped mode, reset and read start rise together, so the previous frame's data read shares the reset phase; this gives the shortest scan. In extended mode, read start is issued on its own after the signal sample. The block then waits a programmed time, then issues reset by itself, followed by a second clock burst. A run is either a programmed number of frames or a free run that ends on a stop request. A one-cycle frame-done pulse marks every signal sample, and a busy flag covers the whole run.

State machine: `ST_IDLE` goes to `ST_RST` on start. Then `ST_RST` → `ST_SETUP` → `ST_CLOCKS` → `ST_SHR_DLY` → `ST_SHR` → `ST_INTG_DLY` → `ST_INTG` → `ST_SHS_DLY` → `ST_SHS` → `ST_GAP`. In overlapped mode `ST_GAP` returns to `ST_RST`, or to `ST_IDLE` when the run is finished. In extended mode `ST_GAP` goes to `ST_STI` → `ST_SETUP` → `ST_CLOCKS` (read burst); that burst ends in `ST_WAIT`, which leads to `ST_RST`, or in `ST_IDLE` when the run is finished.

Top module: `scan_timing_gen`

## Requirements
- R1: After reset, and whenever the block is idle, busy, frame-done, the readout clock and all five strobes are low, and nothing starts until start is seen.
- R2: Reset, reset-sample, signal-sample and read-start each stay high for exactly max(pulse_len, 4) cycles.
- R3: In overlapped mode, reset and read start rise in the same cycle. The first readout clock rising edge comes max(gap_len, 4) + 1 cycles after they fall.
- R4: Each clock burst has exactly 133 rising edges when simult is 0 and exactly 33 when simult is 1.
- R5: Each readout clock half period (high and low) is half_per clamped to [5, 62] cycles when simult is 0 and to [17, 250] cycles when simult is 1.
- R6: Reset-sample rises max(shr_dly, 50) cycles after the last reset-burst clock falls. Integrate enable rises max(gap_len, 4) cycles after reset-sample falls.
- R7: Integrate enable stays high max(intg_len, 1) cycles. Signal-sample rises max(shs_dly, 563) cycles after integrate enable falls.
- R8: In overlapped mode, the next frame's reset rises max(gap_len, 4) cycles after signal-sample falls.
- R9: In extended mode, read start rises alone max(gap_len, 4) cycles after signal-sample falls, and is followed by a read burst. The next reset rises alone max(wait_len, 1) cycles after that burst's last clock falls, and a reset burst follows.
- R10: Frame-done is a one-cycle pulse in the first cycle of each signal-sample strobe. A run of frames_count = N > 0 gives exactly N pulses.
- R11: Busy rises (together with reset) in the cycle after start is captured. It falls max(gap_len, 4) cycles after the final signal-sample falls in overlapped mode, and in the same cycle as the final read burst's last clock fall in extended mode.
- R12: With frames_count = 0 the run repeats frames until stop. A stop raised during the gap after a signal sample ends the run at the end of that gap.
- R13: Start is ignored while busy. The mode inputs are captured at start, so changing them during a run has no effect.
- R14: The readout clock is never high while any of reset, reset-sample, integrate enable or signal-sample is high. The three sampling strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken in idle only |
| stop_i | input | 1 | Stop request for free-run operation |
| overlap_i | input | 1 | 1 = overlapped minimum-scan mode, 0 = extended wait mode |
| simult_i | input | 1 | 1 = 33-clock burst and slow clock band, 0 = 133-clock burst |
| frames_i | input | FRM_W | Frames per run, 0 = free run |
| pulse_len_i | input | CNT_W | Strobe high time in cycles |
| gap_len_i | input | CNT_W | Short gap between strobe edges and setup before the clock |
| shr_dly_i | input | CNT_W | Last burst clock fall to reset-sample rise |
| intg_len_i | input | CNT_W | Integrate enable high time |
| shs_dly_i | input | CNT_W | Integrate enable fall to signal-sample rise |
| wait_len_i | input | CNT_W | Extended-mode wait after the read burst |
| half_per_i | input | CNT_W | Readout clock half period in cycles |
| irst_o | output | 1 | Integrator reset strobe |
| shr_o | output | 1 | Reset-level sample strobe |
| intg_o | output | 1 | Integrate enable |
| shs_o | output | 1 | Signal-level sample strobe |
| sti_o | output | 1 | Read start strobe |
| rdclk_o | output | 1 | Gated readout clock |
| frame_done_o | output | 1 | One-cycle pulse per signal sample |
| busy_o | output | 1 | High during a run |

## Verification
On every cycle the assertions check the minimum strobe widths, that the readout clock is quiet during the strobes, that the sampling strobes never overlap, the burst length limit, the minimum clock half period, the alignment of frame-done with the signal sample, and quiet outputs while idle. The exact spacing between strobe edges, the clamping of register values at both ends, the order of strobes in each mode, frame counting, stop handling, and the ignoring of start and mode changes during a run can only be shown by the bench's directed scenarios. Those scenarios measure edge-to-edge distances in cycles at the ports.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_SETUP,
        ST_CLOCKS,
        ST_SHR_DLY,
        ST_SHR,
        ST_INTG_DLY,
        ST_INTG,
        ST_SHS_DLY,
        ST_SHS,
        ST_GAP,
        ST_STI,
        ST_WAIT
    } scan_state_e;

endpackage

// File: rtl/scan_clamp.sv
module scan_clamp #(
    parameter int          W  = 16,
    parameter int unsigned LO = 1,
    parameter int unsigned HI = 65535
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] eff_o
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    always_comb begin
        if (raw_i < LO_V)      eff_o = LO_V;
        else if (raw_i > HI_V) eff_o = HI_V;
        else                   eff_o = raw_i;
    end
endmodule

// File: rtl/scan_rdclk_gen.sv
module scan_rdclk_gen #(
    parameter int W  = 16,
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [W-1:0]  half_i,
    input  logic [EW-1:0] count_i,
    output logic          rdclk_o,
    output logic          last_o
);
    logic [W-1:0]  cnt_q;
    logic [EW-1:0] edges_q;
    logic          clk_q;

    // final falling edge of the burst happens on the cycle last_o is high
    assign last_o  = run_i && clk_q && (cnt_q == '0) && (edges_q == count_i);
    assign rdclk_o = clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q   <= 1'b0;
            cnt_q   <= '0;
            edges_q <= '0;
        end else if (!run_i) begin
            clk_q   <= 1'b0;
            cnt_q   <= '0;
            edges_q <= '0;
        end else if (edges_q == '0) begin
            clk_q   <= 1'b1;
            edges_q <= EW'(1);
            cnt_q   <= half_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end else if (clk_q) begin
            clk_q <= 1'b0;
            cnt_q <= half_i - W'(1);
        end else begin
            clk_q   <= 1'b1;
            edges_q <= edges_q + EW'(1);
            cnt_q   <= half_i - W'(1);
        end
    end
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
    import scan_pkg::*;
#(
    parameter int          CNT_W        = 16,
    parameter int          FRM_W        = 8,
    parameter int unsigned MIN_PULSE    = 4,
    parameter int unsigned MIN_GAP      = 4,
    parameter int unsigned MIN_SHR_DLY  = 50,
    parameter int unsigned MIN_INTG     = 1,
    parameter int unsigned MIN_SHS_DLY  = 563,
    parameter int unsigned MIN_WAIT     = 1,
    parameter int unsigned SEQ_CLKS     = 133,
    parameter int unsigned SIM_CLKS     = 33,
    parameter int unsigned SEQ_HALF_MIN = 5,
    parameter int unsigned SEQ_HALF_MAX = 62,
    parameter int unsigned SIM_HALF_MIN = 17,
    parameter int unsigned SIM_HALF_MAX = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             overlap_i,
    input  logic             simult_i,
    input  logic [FRM_W-1:0] frames_i,
    input  logic [CNT_W-1:0] pulse_len_i,
    input  logic [CNT_W-1:0] gap_len_i,
    input  logic [CNT_W-1:0] shr_dly_i,
    input  logic [CNT_W-1:0] intg_len_i,
    input  logic [CNT_W-1:0] shs_dly_i,
    input  logic [CNT_W-1:0] wait_len_i,
    input  logic [CNT_W-1:0] half_per_i,
    output logic             irst_o,
    output logic             shr_o,
    output logic             intg_o,
    output logic             shs_o,
    output logic             sti_o,
    output logic             rdclk_o,
    output logic             frame_done_o,
    output logic             busy_o
);
    localparam int unsigned MAX_CNT = (2 ** CNT_W) - 1;
    localparam int          EW      = $clog2(SEQ_CLKS + 1);

    scan_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, dur_d;
    logic [FRM_W-1:0] frames_q;
    logic             free_q, stop_q, ovl_q, sim_q, rd_q, shs_d1_q;
    logic             burst_last, finished;

    logic [CNT_W-1:0] pulse_eff, gap_eff, shrd_eff, intg_eff, shsd_eff, wait_eff;
    logic [CNT_W-1:0] half_seq, half_sim, half_eff;
    logic [EW-1:0]    burst_len;

    // ---------------- register clamping ----------------
    scan_clamp #(.W(CNT_W), .LO(MIN_PULSE),    .HI(MAX_CNT))      u_cl_pulse (.raw_i(pulse_len_i), .eff_o(pulse_eff));
    scan_clamp #(.W(CNT_W), .LO(MIN_GAP),      .HI(MAX_CNT))      u_cl_gap   (.raw_i(gap_len_i),   .eff_o(gap_eff));
    scan_clamp #(.W(CNT_W), .LO(MIN_SHR_DLY),  .HI(MAX_CNT))      u_cl_shrd  (.raw_i(shr_dly_i),   .eff_o(shrd_eff));
    scan_clamp #(.W(CNT_W), .LO(MIN_INTG),     .HI(MAX_CNT))      u_cl_intg  (.raw_i(intg_len_i),  .eff_o(intg_eff));
    scan_clamp #(.W(CNT_W), .LO(MIN_SHS_DLY),  .HI(MAX_CNT))      u_cl_shsd  (.raw_i(shs_dly_i),   .eff_o(shsd_eff));
    scan_clamp #(.W(CNT_W), .LO(MIN_WAIT),     .HI(MAX_CNT))      u_cl_wait  (.raw_i(wait_len_i),  .eff_o(wait_eff));
    scan_clamp #(.W(CNT_W), .LO(SEQ_HALF_MIN), .HI(SEQ_HALF_MAX)) u_cl_hseq  (.raw_i(half_per_i),  .eff_o(half_seq));
    scan_clamp #(.W(CNT_W), .LO(SIM_HALF_MIN), .HI(SIM_HALF_MAX)) u_cl_hsim  (.raw_i(half_per_i),  .eff_o(half_sim));

    assign half_eff  = sim_q ? half_sim : half_seq;
    assign burst_len = sim_q ? EW'(SIM_CLKS) : EW'(SEQ_CLKS);

    // ---------------- readout clock burst ----------------
    scan_rdclk_gen #(.W(CNT_W), .EW(EW)) u_rdclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state_q == ST_CLOCKS),
        .half_i  (half_eff),
        .count_i (burst_len),
        .rdclk_o (rdclk_o),
        .last_o  (burst_last)
    );

    assign finished = free_q ? stop_q : (frames_q == '0);

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i)         state_d = ST_RST;
            ST_RST:      if (cnt_q == '0)     state_d = ST_SETUP;
            ST_SETUP:    if (cnt_q == '0)     state_d = ST_CLOCKS;
            ST_CLOCKS:   if (burst_last)      state_d = !rd_q ? ST_SHR_DLY
                                                      : (finished ? ST_IDLE : ST_WAIT);
            ST_SHR_DLY:  if (cnt_q == '0)     state_d = ST_SHR;
            ST_SHR:      if (cnt_q == '0)     state_d = ST_INTG_DLY;
            ST_INTG_DLY: if (cnt_q == '0)     state_d = ST_INTG;
            ST_INTG:     if (cnt_q == '0)     state_d = ST_SHS_DLY;
            ST_SHS_DLY:  if (cnt_q == '0)     state_d = ST_SHS;
            ST_SHS:      if (cnt_q == '0)     state_d = ST_GAP;
            ST_GAP:      if (cnt_q == '0)     state_d = !ovl_q ? ST_STI
                                                      : (finished ? ST_IDLE : ST_RST);
            ST_STI:      if (cnt_q == '0)     state_d = ST_SETUP;
            ST_WAIT:     if (cnt_q == '0)     state_d = ST_RST;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // length of the state being entered
    always_comb begin
        unique case (state_d)
            ST_RST, ST_SHR, ST_SHS, ST_STI: dur_d = pulse_eff;
            ST_SETUP, ST_INTG_DLY, ST_GAP:  dur_d = gap_eff;
            ST_SHR_DLY:                     dur_d = shrd_eff;
            ST_INTG:                        dur_d = intg_eff;
            ST_SHS_DLY:                     dur_d = shsd_eff;
            ST_WAIT:                        dur_d = wait_eff;
            default:                        dur_d = CNT_W'(1);
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            frames_q <= '0;
            free_q   <= 1'b0;
            stop_q   <= 1'b0;
            ovl_q    <= 1'b0;
            sim_q    <= 1'b0;
            rd_q     <= 1'b0;
            shs_d1_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            shs_d1_q <= shs_o;
            if (state_d != state_q)  cnt_q <= dur_d - CNT_W'(1);
            else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);

            if (state_q == ST_IDLE && start_i) begin
                frames_q <= frames_i;
                free_q   <= (frames_i == '0);
                ovl_q    <= overlap_i;
                sim_q    <= simult_i;
                stop_q   <= 1'b0;
            end else begin
                if (stop_i) stop_q <= 1'b1;
                if (frame_done_o && !free_q && frames_q != '0)
                    frames_q <= frames_q - FRM_W'(1);
            end

            if (state_d == ST_STI)      rd_q <= 1'b1;
            else if (state_d == ST_RST) rd_q <= 1'b0;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        irst_o       = (state_q == ST_RST);
        sti_o        = (state_q == ST_RST && ovl_q) || (state_q == ST_STI);
        shr_o        = (state_q == ST_SHR);
        intg_o       = (state_q == ST_INTG);
        shs_o        = (state_q == ST_SHS);
        busy_o       = (state_q != ST_IDLE);
        frame_done_o = shs_o && !shs_d1_q;
    end
endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk #(
    parameter int unsigned MIN_PULSE    = 4,
    parameter int unsigned SEQ_CLKS     = 133,
    parameter int unsigned SIM_CLKS     = 33,
    parameter int unsigned SEQ_HALF_MIN = 5,
    parameter int unsigned SIM_HALF_MIN = 17
) (
    input logic clk,
    input logic rst_n,
    input logic irst,
    input logic sti,
    input logic shr,
    input logic intg,
    input logic shs,
    input logic rdclk,
    input logic frame_done,
    input logic busy,
    input logic sim
);
    logic [15:0] run_irst, run_sti, run_shr, run_shs, run_clk, n_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_irst <= '0; run_sti <= '0; run_shr <= '0;
            run_shs  <= '0; run_clk <= '0; n_rise  <= '0;
        end else begin
            run_irst <= irst  ? run_irst + 16'd1 : '0;
            run_sti  <= sti   ? run_sti  + 16'd1 : '0;
            run_shr  <= shr   ? run_shr  + 16'd1 : '0;
            run_shs  <= shs   ? run_shs  + 16'd1 : '0;
            run_clk  <= rdclk ? run_clk  + 16'd1 : '0;
            if (irst || sti)               n_rise <= '0;
            else if (rdclk && run_clk == 0) n_rise <= n_rise + 16'd1;
        end
    end

    p_irst_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irst) |-> run_irst >= 16'(MIN_PULSE));
    p_sti_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sti) |-> run_sti >= 16'(MIN_PULSE));
    p_shr_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shr) |-> run_shr >= 16'(MIN_PULSE));
    p_shs_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shs) |-> run_shs >= 16'(MIN_PULSE));
    p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdclk) |-> n_rise < (sim ? 16'(SIM_CLKS) : 16'(SEQ_CLKS)));
    p_clk_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdclk) |-> run_clk >= (sim ? 16'(SIM_HALF_MIN) : 16'(SEQ_HALF_MIN)));
    p_done_on_shs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $rose(shs));
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    p_clk_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
        rdclk |-> !(irst || shr || intg || shs));
    p_samples_excl_r14: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shr, intg, shs}));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(irst || sti || shr || intg || shs || rdclk || frame_done));
endmodule

bind scan_timing_gen scan_timing_chk #(
    .MIN_PULSE    (MIN_PULSE),
    .SEQ_CLKS     (SEQ_CLKS),
    .SIM_CLKS     (SIM_CLKS),
    .SEQ_HALF_MIN (SEQ_HALF_MIN),
    .SIM_HALF_MIN (SIM_HALF_MIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irst       (irst_o),
    .sti        (sti_o),
    .shr        (shr_o),
    .intg       (intg_o),
    .shs        (shs_o),
    .rdclk      (rdclk_o),
    .frame_done (frame_done_o),
    .busy       (busy_o),
    .sim        (sim_q)
);

// File: tb/scan_timing_gen_tb.sv
module scan_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, overlap_i = 1'b1, simult_i = 1'b0;
    logic [7:0]  frames_i = 8'd1;
    logic [15:0] pulse_len_i = 0, gap_len_i = 0, shr_dly_i = 0, intg_len_i = 0;
    logic [15:0] shs_dly_i = 0, wait_len_i = 0, half_per_i = 0;
    logic irst, shr, intg, shs, sti, rdclk, frame_done, busy;

    always #4 clk = ~clk;

    scan_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .overlap_i(overlap_i), .simult_i(simult_i), .frames_i(frames_i),
        .pulse_len_i(pulse_len_i), .gap_len_i(gap_len_i), .shr_dly_i(shr_dly_i),
        .intg_len_i(intg_len_i), .shs_dly_i(shs_dly_i), .wait_len_i(wait_len_i),
        .half_per_i(half_per_i), .irst_o(irst), .shr_o(shr), .intg_o(intg),
        .shs_o(shs), .sti_o(sti), .rdclk_o(rdclk), .frame_done_o(frame_done),
        .busy_o(busy)
    );

    int n_total = 0, n_fail = 0, wd = 0;

    // ---------------- port monitor (negedge sampling) ----------------
    int cyc = 0;
    logic p_irst = 0, p_sti = 0, p_shr = 0, p_intg = 0, p_shs = 0, p_clk = 0, p_busy = 0, p_done = 0;
    int t_irst_r, t_sti_r, t_clk_r, t_clk_f, t_shr_r, t_shr_f, t_intg_r, t_intg_f, t_shs_r, t_shs_f, ref_f;
    int w_irst, w_sti, w_shr, w_shs, w_intg, w_clkh, w_clkl;
    int d_first, d_shs_irst, d_shs_sti, d_cf_irst, d_cf_shr, d_shr_intg, d_intg_shs;
    int d_shs_busy, d_cf_busy, n_clk, n_clk_shr, n_clk_end;
    int n_both, n_alone, n_done, n_done_bad, n_busy_fall;
    bit first_pend;

    always @(negedge clk) begin
        cyc++;
        if (irst && !p_irst) begin
            t_irst_r = cyc; n_clk = 0; first_pend = 1;
            d_shs_irst = cyc - t_shs_f; d_cf_irst = cyc - t_clk_f;
            if (sti) n_both++; else n_alone++;
        end
        if (!irst && p_irst) begin w_irst = cyc - t_irst_r; ref_f = cyc; end
        if (sti && !p_sti) begin
            t_sti_r = cyc; n_clk = 0; first_pend = 1;
            if (!irst) d_shs_sti = cyc - t_shs_f;
        end
        if (!sti && p_sti) begin w_sti = cyc - t_sti_r; ref_f = cyc; end
        if (rdclk && !p_clk) begin
            if (first_pend) begin d_first = cyc - ref_f; first_pend = 0; end
            else w_clkl = cyc - t_clk_f;
            n_clk++; t_clk_r = cyc;
        end
        if (!rdclk && p_clk) begin w_clkh = cyc - t_clk_r; t_clk_f = cyc; end
        if (shr && !p_shr) begin t_shr_r = cyc; d_cf_shr = cyc - t_clk_f; n_clk_shr = n_clk; end
        if (!shr && p_shr) begin w_shr = cyc - t_shr_r; t_shr_f = cyc; end
        if (intg && !p_intg) begin t_intg_r = cyc; d_shr_intg = cyc - t_shr_f; end
        if (!intg && p_intg) begin w_intg = cyc - t_intg_r; t_intg_f = cyc; end
        if (shs && !p_shs) begin t_shs_r = cyc; d_intg_shs = cyc - t_intg_f; end
        if (!shs && p_shs) begin w_shs = cyc - t_shs_r; t_shs_f = cyc; end
        if (frame_done) begin
            n_done++;
            if (!(shs && !p_shs) || p_done) n_done_bad++;
        end
        if (!busy && p_busy) begin
            d_shs_busy = cyc - t_shs_f; d_cf_busy = cyc - t_clk_f;
            n_clk_end = n_clk; n_busy_fall++;
        end
        p_irst = irst; p_sti = sti; p_shr = shr; p_intg = intg; p_shs = shs;
        p_clk = rdclk; p_busy = busy; p_done = frame_done;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_meas();
        n_both = 0; n_alone = 0; n_done = 0; n_done_bad = 0; n_busy_fall = 0;
    endtask

    task automatic set_regs(input int pl, input int gp, input int sd, input int il,
                            input int hd, input int wl, input int hp);
        pulse_len_i = 16'(pl); gap_len_i = 16'(gp); shr_dly_i = 16'(sd);
        intg_len_i = 16'(il); shs_dly_i = 16'(hd); wait_len_i = 16'(wl); half_per_i = 16'(hp);
    endtask

    // start pulse; R11 busy and reset rise in the cycle after capture
    task automatic kick();
        @(posedge clk); #1 start_i = 1'b1;
        @(negedge clk);
        @(posedge clk); #1 start_i = 1'b0;
        @(negedge clk);
        chk("R11 busy after start", int'(busy), 1);
        chk("R11 reset with busy", int'(irst), 1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk("R1 busy idle", int'(busy), 0);
        chk("R1 strobes idle", int'({irst, sti, shr, intg, shs}), 0);
        chk("R1 rdclk idle", int'(rdclk), 0);
        chk("R1 frame_done idle", int'(frame_done), 0);
    endtask

    task automatic t_overlap_seq();
        clear_meas();
        overlap_i = 1; simult_i = 0; frames_i = 2;
        set_regs(2, 1, 10, 100, 0, 0, 1);
        kick();
        wait_idle();
        chk("R2 irst width", w_irst, 4);
        chk("R2 sti width", w_sti, 4);
        chk("R2 shr width", w_shr, 4);
        chk("R2 shs width", w_shs, 4);
        chk("R3 joint rises", n_both, 2);
        chk("R3 lone resets", n_alone, 0);
        chk("R3 first clock", d_first, 5);
        chk("R4 seq burst", n_clk_shr, 133);
        chk("R5 seq high min", w_clkh, 5);
        chk("R5 seq low min", w_clkl, 5);
        chk("R6 shr delay", d_cf_shr, 50);
        chk("R6 intg after shr", d_shr_intg, 4);
        chk("R7 intg width", w_intg, 100);
        chk("R7 shs delay", d_intg_shs, 563);
        chk("R8 next reset", d_shs_irst, 4);
        chk("R10 frame count", n_done, 2);
        chk("R10 done alignment", n_done_bad, 0);
        chk("R11 busy end overlap", d_shs_busy, 4);
    endtask

    task automatic t_overlap_sim();
        clear_meas();
        overlap_i = 1; simult_i = 1; frames_i = 1;
        set_regs(10, 20, 80, 0, 600, 0, 2);
        kick();
        overlap_i = 0; simult_i = 0;       // R13 changes after capture
        repeat (10) @(negedge clk);
        @(posedge clk); #1 start_i = 1'b1; // R13 start while busy
        @(posedge clk); #1 start_i = 1'b0;
        wait_idle();
        chk("R2 long strobe", w_irst, 10);
        chk("R3 first clock sim", d_first, 21);
        chk("R4 sim burst", n_clk_shr, 33);
        chk("R5 sim high min", w_clkh, 17);
        chk("R6 shr delay long", d_cf_shr, 80);
        chk("R7 intg min", w_intg, 1);
        chk("R7 shs delay long", d_intg_shs, 600);
        chk("R13 start ignored", n_done, 1);
        chk("R13 mode kept", n_both, 1);
        chk("R13 no extra run", n_busy_fall, 1);
    endtask

    task automatic t_half_max();
        clear_meas();
        overlap_i = 1; simult_i = 0; frames_i = 1;
        set_regs(4, 4, 50, 10, 563, 0, 100);
        kick(); wait_idle();
        chk("R5 seq high max", w_clkh, 62);
        chk("R5 seq low max", w_clkl, 62);
        clear_meas();
        simult_i = 1; half_per_i = 16'd300;
        kick(); wait_idle();
        chk("R5 sim high max", w_clkh, 250);
        chk("R4 sim burst again", n_clk_shr, 33);
    endtask

    task automatic t_extended();
        clear_meas();
        overlap_i = 0; simult_i = 0; frames_i = 2;
        set_regs(5, 6, 60, 50, 600, 30, 6);
        kick(); wait_idle();
        chk("R9 lone resets", n_alone, 2);
        chk("R9 no joint rise", n_both, 0);
        chk("R9 sti after shs", d_shs_sti, 6);
        chk("R9 read first clock", d_first, 7);
        chk("R9 wait before reset", d_cf_irst, 30);
        chk("R4 read burst", n_clk_end, 133);
        chk("R4 reset burst ext", n_clk_shr, 133);
        chk("R2 sti width ext", w_sti, 5);
        chk("R5 seq mid", w_clkh, 6);
        chk("R10 frame count ext", n_done, 2);
        chk("R11 busy end ext", d_cf_busy, 0);
    endtask

    task automatic t_free_run();
        int seen;
        clear_meas();
        overlap_i = 1; simult_i = 1; frames_i = 0;
        set_regs(4, 4, 50, 10, 563, 0, 17);
        kick();
        seen = 0;
        while (seen < 2) begin
            @(negedge clk);
            if (frame_done) seen++;
        end
        @(posedge clk); #1 stop_i = 1'b1;
        @(posedge clk); #1 stop_i = 1'b0;
        wait_idle();
        chk("R12 frames before stop", n_done, 2);
        chk("R12 stop at boundary", d_shs_busy, 4);
        chk("R12 run ended", int'(busy), 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            n_total++; n_fail++;
            $display("FAIL R11 watchdog: cycles %0d expected below %0d", wd, 190000);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_overlap_seq();
        t_overlap_sim();
        t_half_max();
        t_extended();
        t_free_run();
        summary();
        $finish;
    end
endmodule